// File: doc/BRIEF.md
# Dual Data Pointer Unit

This block holds two 16-bit address pointers and one byte-wide control register for an 8051-style processor core. The core reports which pointer instruction class runs in a given cycle. The classes are step, load immediate, code read, external read and external write. The block then updates the pointer that is currently active. The active pointer always drives the external address output.

Each pointer has its own step direction bit, so a step can count up or down. An auto-swap bit makes the active pointer alternate after every pointer instruction. With one pointer set up as the source and the other as the destination, a block copy needs no explicit select changes.

The register file reaches all four pointer bytes and the control register through a small local index space. Writes take effect at the next clock edge. Reads are combinational.

Top module: `dptr_unit`

## Requirements
- R1: A synchronous active-low reset clears both pointers and the control register, so every register reads 0x00 and `ext_addr` is 0x0000 after reset.
- R2: `ext_addr` equals pointer 0 while the select bit (control bit 0) is 0, and equals pointer 1 while it is 1.
- R3: The local register index map is as follows. Index 0 is pointer 0 low byte and index 1 is pointer 0 high byte. Index 2 is pointer 1 low byte and index 3 is pointer 1 high byte. Index 4 is the control register. Indices 5 to 7 read 0x00 and ignore writes. Register writes land at the next clock edge, and reads are combinational.
- R4: Control bits 4 to 1 always read 0, and writes to them have no effect.
- R5: The step instruction (op code 1) adds 1 to the active pointer when that pointer's direction bit is 0, and subtracts 1 when it is 1. Bit 6 is the direction bit of pointer 0, and bit 7 is the direction bit of pointer 1.
- R6: Stepping wraps modulo 2^16: 0xFFFF steps up to 0x0000, and 0x0000 steps down to 0xFFFF.
- R7: Step and load change only the active pointer. The other pointer keeps its value.
- R8: The load instruction (op code 2) copies `load_value` into the active pointer.
- R9: When the swap bit (control bit 5) is 1, the select bit inverts after each of op codes 1 to 5. The pointer update in that cycle applies to the pointer that was active before the swap.
- R10: The code read, external read and external write op codes (3, 4, 5) leave both pointers unchanged. Op codes 0, 6 and 7 change no state.
- R11: A register write to a pointer byte cancels the instruction update of that pointer in the same cycle. A write to the control register overrides the auto-swap in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| op_code | input | 3 | Pointer instruction class: 0 none, 1 step, 2 load, 3 code read, 4 external read, 5 external write |
| load_value | input | 16 | Immediate for the load instruction |
| reg_wr_en | input | 1 | Register write strobe |
| reg_wr_idx | input | 3 | Register write index |
| reg_wr_data | input | 8 | Register write data |
| reg_rd_idx | input | 3 | Register read index |
| reg_rd_data | output | 8 | Register read data |
| ext_addr | output | 16 | Active pointer value |

## Verification
The bench goes after the wrap points in both directions. A design that sizes the adder wrongly or mixes up the direction bits would give 0x10000-style carries or step the wrong way.

It also goes after the auto-swap, where the pointer update must land on the pointer that was active before the swap. Getting this order wrong would step the other pointer.

Same-cycle collisions between register writes and instructions are driven on purpose. A wrong priority would either lose the software write or apply a step on top of it.

Random traffic then mixes all op codes, including the unused ones, with writes to every index. The reserved control bits and unmapped indices must keep reading zero throughout.

// File: rtl/dptr_pkg.sv
// Shared definitions for the dual data pointer unit.
// Assumes the core drives op codes as encoded below; codes 6 and 7 are idle.
package dptr_pkg;
    typedef enum logic [2:0] {
        OP_IDLE    = 3'd0,
        OP_STEP    = 3'd1,
        OP_LOAD    = 3'd2,
        OP_CODE_RD = 3'd3,
        OP_EXT_RD  = 3'd4,
        OP_EXT_WR  = 3'd5
    } ptr_op_e;

    // Control register bit positions (byte-wide register).
    localparam int CTL_SEL_BIT  = 0;
    localparam int CTL_SWAP_BIT = 5;
    localparam int CTL_DIR0_BIT = 6;
    localparam int CTL_DIR1_BIT = 7;

    typedef struct packed {
        logic [1:0] dir;   // per-pointer count-down flags
        logic       swap;  // auto-swap after pointer instructions
        logic       sel;   // active pointer
    } ptr_ctl_t;

    // True for every instruction class that triggers an auto-swap.
    function automatic logic is_ptr_op(input logic [2:0] code);
        return (code >= 3'd1) && (code <= 3'd5);
    endfunction
endpackage

// File: rtl/dptr_reg.sv
// One address pointer with byte-wise register writes, load and up/down step.
// Assumes byte writes outrank load, and load outranks step; the caller
// asserts at most one of load_en/step_en.
module dptr_reg #(
    parameter  int PTR_W  = 16,
    parameter  int DATA_W = 8,
    localparam int NB     = PTR_W / DATA_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NB-1:0]     byte_wr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              load_en,
    input  logic [PTR_W-1:0]  load_val,
    input  logic              step_en,
    input  logic              count_down,
    output logic [PTR_W-1:0]  value
);
    logic [PTR_W-1:0] ptr_q;

    // Pointer state: reset, software byte writes, then instruction update.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ptr_q <= '0;
        end else if (|byte_wr) begin
            for (int b = 0; b < NB; b++) begin
                if (byte_wr[b]) ptr_q[b*DATA_W +: DATA_W] <= wr_data;
            end
        end else if (load_en) begin
            ptr_q <= load_val;
        end else if (step_en) begin
            ptr_q <= count_down ? ptr_q - 1'b1 : ptr_q + 1'b1;
        end
    end

    assign value = ptr_q;
endmodule

// File: rtl/dptr_ctl.sv
// Control register: active select, auto-swap enable and two direction flags.
// Assumes DATA_W is 8 so the fixed bit positions of the package fit.
module dptr_ctl
    import dptr_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ctl_wr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [2:0]        op_code,
    output ptr_ctl_t          ctl
);
    ptr_ctl_t ctl_q;

    // Control state: software write wins over the auto-swap.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctl_q <= '0;
        end else if (ctl_wr) begin
            ctl_q.sel    <= wr_data[CTL_SEL_BIT];
            ctl_q.swap   <= wr_data[CTL_SWAP_BIT];
            ctl_q.dir[0] <= wr_data[CTL_DIR0_BIT];
            ctl_q.dir[1] <= wr_data[CTL_DIR1_BIT];
        end else if (ctl_q.swap && is_ptr_op(op_code)) begin
            ctl_q.sel <= ~ctl_q.sel;
        end
    end

    assign ctl = ctl_q;
endmodule

// File: rtl/dptr_unit.sv
// Top of the dual data pointer unit: register index decode, two pointers,
// the control register, read-back mux and the external address.
// Assumes the register indices of the brief; reserved bits read 0.
module dptr_unit
    import dptr_pkg::*;
#(
    parameter  int PTR_W   = 16,
    parameter  int DATA_W  = 8,
    parameter  int IDX_W   = 3,
    localparam int NB      = PTR_W / DATA_W,
    localparam int N_PTR   = 2,
    localparam int CTL_IDX = N_PTR * NB
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [2:0]        op_code,
    input  logic [PTR_W-1:0]  load_value,
    input  logic              reg_wr_en,
    input  logic [IDX_W-1:0]  reg_wr_idx,
    input  logic [DATA_W-1:0] reg_wr_data,
    input  logic [IDX_W-1:0]  reg_rd_idx,
    output logic [DATA_W-1:0] reg_rd_data,
    output logic [PTR_W-1:0]  ext_addr
);
    ptr_ctl_t         ctl;
    logic [PTR_W-1:0] ptr_q [N_PTR];
    logic             ctl_wr;

    assign ctl_wr = reg_wr_en && (reg_wr_idx == IDX_W'(CTL_IDX));

    dptr_ctl #(.DATA_W(DATA_W)) u_ctl (
        .clk     (clk),
        .rst_n   (rst_n),
        .ctl_wr  (ctl_wr),
        .wr_data (reg_wr_data),
        .op_code (op_code),
        .ctl     (ctl)
    );

    for (genvar g = 0; g < N_PTR; g++) begin : g_ptr
        logic [NB-1:0] byte_wr;
        logic          active;

        // Byte write decode for this pointer.
        always_comb begin
            for (int b = 0; b < NB; b++) begin
                byte_wr[b] = reg_wr_en && (reg_wr_idx == IDX_W'(g*NB + b));
            end
        end

        assign active = (ctl.sel == 1'(g));

        dptr_reg #(.PTR_W(PTR_W), .DATA_W(DATA_W)) u_reg (
            .clk        (clk),
            .rst_n      (rst_n),
            .byte_wr    (byte_wr),
            .wr_data    (reg_wr_data),
            .load_en    (active && (op_code == OP_LOAD)),
            .load_val   (load_value),
            .step_en    (active && (op_code == OP_STEP)),
            .count_down (ctl.dir[g]),
            .value      (ptr_q[g])
        );
    end

    // Read-back mux over pointer bytes and the control register.
    always_comb begin
        reg_rd_data = '0;
        for (int p = 0; p < N_PTR; p++) begin
            for (int b = 0; b < NB; b++) begin
                if (reg_rd_idx == IDX_W'(p*NB + b)) reg_rd_data = ptr_q[p][b*DATA_W +: DATA_W];
            end
        end
        if (reg_rd_idx == IDX_W'(CTL_IDX)) begin
            reg_rd_data[CTL_SEL_BIT]  = ctl.sel;
            reg_rd_data[CTL_SWAP_BIT] = ctl.swap;
            reg_rd_data[CTL_DIR0_BIT] = ctl.dir[0];
            reg_rd_data[CTL_DIR1_BIT] = ctl.dir[1];
        end
    end

    assign ext_addr = ctl.sel ? ptr_q[1] : ptr_q[0];
endmodule

// File: rtl/dptr_unit_chk.sv
// Temporal checks on the dual data pointer unit, bound to its top.
// Assumes visibility of the pointer and control state through the bind.
module dptr_unit_chk #(
    parameter int PTR_W = 16
) (
    input logic             clk,
    input logic             rst_n,
    input logic [2:0]       op_code,
    input logic             reg_wr_en,
    input logic [PTR_W-1:0] ptr0,
    input logic [PTR_W-1:0] ptr1,
    input logic             sel,
    input logic             swap,
    input logic [1:0]       dir
);
    // R1
    reset_clear_chk: assert property (@(posedge clk)
        !rst_n |=> (ptr0 == '0) && (ptr1 == '0) && !sel && !swap && (dir == 2'b00));

    // R5
    step_up_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (op_code == 3'd1 && !reg_wr_en && !sel && !dir[0])
        |=> ptr0 == PTR_W'($past(ptr0) + 1'b1));

    // R5
    step_down_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (op_code == 3'd1 && !reg_wr_en && sel && dir[1])
        |=> ptr1 == PTR_W'($past(ptr1) - 1'b1));

    // R7
    other_ptr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (op_code == 3'd1 && !reg_wr_en && !sel) |=> $stable(ptr1));

    // R9
    auto_swap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (op_code >= 3'd1 && op_code <= 3'd5 && swap && !reg_wr_en)
        |=> sel != $past(sel));

    // R10
    idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((op_code == 3'd0 || op_code >= 3'd6) && !reg_wr_en)
        |=> $stable(ptr0) && $stable(ptr1) && $stable(sel));
endmodule

bind dptr_unit dptr_unit_chk #(.PTR_W(PTR_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .op_code   (op_code),
    .reg_wr_en (reg_wr_en),
    .ptr0      (ptr_q[0]),
    .ptr1      (ptr_q[1]),
    .sel       (ctl.sel),
    .swap      (ctl.swap),
    .dir       (ctl.dir)
);

// File: tb/dptr_unit_tb.sv
// Bench: behavioural reference model compared with the ports on every clock.
module dptr_unit_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [2:0]  op_code = '0;
    logic [15:0] load_value = '0;
    logic        reg_wr_en = 1'b0;
    logic [2:0]  reg_wr_idx = '0;
    logic [7:0]  reg_wr_data = '0;
    logic [2:0]  reg_rd_idx = '0;
    logic [7:0]  reg_rd_data;
    logic [15:0] ext_addr;

    int n_chk = 0;
    int n_fail = 0;

    // Reference state
    int m_ptr [2];
    bit m_sel, m_swap;
    bit m_dir [2];

    always #2 clk = ~clk;

    dptr_unit u_dut (
        .clk(clk), .rst_n(rst_n), .op_code(op_code), .load_value(load_value),
        .reg_wr_en(reg_wr_en), .reg_wr_idx(reg_wr_idx), .reg_wr_data(reg_wr_data),
        .reg_rd_idx(reg_rd_idx), .reg_rd_data(reg_rd_data), .ext_addr(ext_addr)
    );

    task automatic check(input string tag, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic int exp_rd(input int idx);
        case (idx)
            0: return m_ptr[0] & 'hFF;
            1: return (m_ptr[0] >> 8) & 'hFF;
            2: return m_ptr[1] & 'hFF;
            3: return (m_ptr[1] >> 8) & 'hFF;
            4: return (int'(m_dir[1]) << 7) | (int'(m_dir[0]) << 6) | (int'(m_swap) << 5) | int'(m_sel);
            default: return 0;
        endcase
    endfunction

    task automatic model_reset();
        m_ptr[0] = 0; m_ptr[1] = 0; m_sel = 0; m_swap = 0; m_dir[0] = 0; m_dir[1] = 0;
    endtask

    task automatic model_apply(input int op, input int ld, input bit we, input int wa, input int wd);
        int old_sel = int'(m_sel);
        for (int i = 0; i < 2; i++) begin
            bit hit = we && (wa == 2*i || wa == 2*i + 1);
            if (hit) begin
                if (wa % 2 == 1) m_ptr[i] = (m_ptr[i] & 'h00FF) | (wd << 8);
                else             m_ptr[i] = (m_ptr[i] & 'hFF00) | wd;
            end else if (old_sel == i) begin
                if (op == 2)      m_ptr[i] = ld;
                else if (op == 1) m_ptr[i] = (m_ptr[i] + (m_dir[i] ? -1 : 1)) & 'hFFFF;
            end
        end
        if (we && wa == 4) begin
            m_sel = wd[0]; m_swap = wd[5]; m_dir[0] = wd[6]; m_dir[1] = wd[7];
        end else if (op >= 1 && op <= 5 && m_swap) begin
            m_sel = ~m_sel;
        end
    endtask

    // One clock: drive at negedge, update model at posedge, compare 1 ns later.
    task automatic cyc(input int op, input int ld, input bit we, input int wa,
                       input int wd, input int ra, input string tag);
        @(negedge clk);
        op_code = 3'(op); load_value = 16'(ld); reg_wr_en = we;
        reg_wr_idx = 3'(wa); reg_wr_data = 8'(wd); reg_rd_idx = 3'(ra);
        @(posedge clk);
        model_apply(op, ld, we, wa, wd);
        #1;
        check(tag, int'(ext_addr), m_sel ? m_ptr[1] : m_ptr[0]);
        check(tag, int'(reg_rd_data), exp_rd(ra));
    endtask

    task automatic wr(input int wa, input int wd, input int ra, input string tag);
        cyc(0, 0, 1'b1, wa, wd, ra, tag);
    endtask

    task automatic idle(input int ra, input string tag);
        cyc(0, 0, 1'b0, 0, 0, ra, tag);
    endtask

    initial begin
        #2000000;
        n_chk++; n_fail++;
        $display("FAIL R1 watchdog actual=running expected=finished");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        // R1: reset with a write attempted while reset is low
        model_reset();
        reg_wr_en = 1'b1; reg_wr_idx = 3'd0; reg_wr_data = 8'hAA;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1; reg_wr_en = 1'b0;
        for (int r = 0; r < 8; r++) idle(r, "R1");

        // R3: byte map write and read-back, unmapped index ignored
        wr(0, 'h34, 0, "R3"); wr(1, 'h12, 1, "R3");
        wr(2, 'hCD, 2, "R3"); wr(3, 'hAB, 3, "R3");
        wr(6, 'hFF, 6, "R3");
        for (int r = 0; r < 8; r++) idle(r, "R3");

        // R2: select chooses the output pointer
        idle(4, "R2");
        wr(4, 'h01, 4, "R2");
        wr(4, 'h00, 4, "R2");

        // R4: reserved control bits
        wr(4, 'h1E, 4, "R4");
        wr(4, 'hFF, 4, "R4");
        wr(4, 'h00, 4, "R4");

        // R5: up and down stepping on each pointer, R7 other pointer held
        repeat (3) cyc(1, 0, 0, 0, 0, 2, "R5");
        idle(3, "R7");
        wr(4, 'h40, 4, "R5");
        repeat (2) cyc(1, 0, 0, 0, 0, 3, "R5");
        wr(4, 'h81, 4, "R5");
        repeat (2) cyc(1, 0, 0, 0, 0, 0, "R7");
        wr(4, 'h01, 4, "R5");
        cyc(1, 0, 0, 0, 0, 1, "R7");

        // R6: wrap both ways on pointer 0
        wr(4, 'h00, 4, "R6");
        wr(0, 'hFF, 0, "R6"); wr(1, 'hFF, 1, "R6");
        cyc(1, 0, 0, 0, 0, 1, "R6");
        wr(4, 'h40, 4, "R6");
        cyc(1, 0, 0, 0, 0, 0, "R6");
        cyc(1, 0, 0, 0, 0, 1, "R6");

        // R8: load into each pointer
        cyc(2, 'h5A5A, 0, 0, 0, 0, "R8");
        wr(4, 'h01, 4, "R8");
        cyc(2, 'hC3E1, 0, 0, 0, 3, "R8");
        idle(1, "R7");

        // R9: auto-swap after every pointer op class
        wr(4, 'h20, 4, "R9");
        for (int op = 1; op <= 5; op++) cyc(op, 'h0F0F, 0, 0, 0, 4, "R9");
        cyc(1, 0, 0, 0, 0, 2, "R9");
        cyc(1, 0, 0, 0, 0, 0, "R9");

        // R10: access ops and idle codes change nothing
        wr(4, 'h00, 4, "R10");
        for (int op = 3; op <= 7; op++) cyc(op, 'hFFFF, 0, 0, 0, 0, "R10");
        cyc(0, 'h1111, 0, 0, 0, 1, "R10");

        // R11: write collides with step on active pointer, then control vs swap
        cyc(1, 0, 1'b1, 0, 'h77, 0, "R11");
        idle(1, "R11");
        cyc(2, 'h9999, 1'b1, 1, 'h66, 1, "R11");
        idle(0, "R11");
        cyc(1, 0, 1'b1, 2, 'h55, 2, "R11");
        wr(4, 'h20, 4, "R11");
        cyc(1, 0, 1'b1, 4, 'h20, 4, "R11");
        cyc(3, 0, 1'b1, 4, 'h21, 4, "R11");

        // Mixed random traffic over all codes and indices
        for (int k = 0; k < 400; k++) begin
            bit we = ($urandom_range(0, 3) == 0);
            cyc($urandom_range(0, 7), $urandom_range(0, 'hFFFF), we,
                $urandom_range(0, 7), $urandom_range(0, 'hFF), $urandom_range(0, 7), "R7");
        end

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule